// File: doc/BRIEF.md
# Elastic Valid/Stall Interlocked Pipeline

A chain of `STAGES` flip-flop registers that moves data items from a producer to a consumer. Adjacent registers are coupled by a forward valid flag and a backward stall flag. Each register accepts a new item only when the item is valid and the register itself is not held. The number of items in flight can therefore vary from zero up to the stage count. Gaps between items close up while the consumer holds off, and the producer is blocked only when every stage is occupied.

A stage passes a stall upstream only while it holds an item, so empty slots never block the stages behind them. The backward stall chain is purely combinational and settles while the clock is low. Each stage has two enable latches, both transparent during the low phase. They gate separate clocks for the data register and for the valid flag, so an idle or held stage receives no clock pulse.

Top module: `elastic_pipe`

## Requirements
- R1: While and after `rst_ni` is low, `valid_o` is 0 and `stall_o` is 0, even with `stall_i` at 1.
- R2: An item on `data_i` is taken at a rising edge exactly when `valid_i` is 1 and `stall_o` is 0 in the clock-low phase before that edge; it is not taken otherwise.
- R3: `stall_o` is 1 exactly when `stall_i` is 1 and all `STAGES` stages hold an item; an empty stage never passes a stall upstream.
- R4: An item accepted into an empty pipeline with `stall_i` held at 0 shows up on `valid_o`/`data_o` after `STAGES` rising edges, counting the edge that accepts it.
- R5: Items leave in the order they were accepted, each exactly once, none lost.
- R6: While `valid_o` is 1 and `stall_i` is 1, `valid_o` and `data_o` remain unchanged across the next rising edge.
- R7: An item on the output is consumed at a rising edge when `valid_o` is 1 and `stall_i` is 0.
- R8: A stage that is not held and sees no valid input becomes empty at the edge, so a gap in the input stream reaches the output as a gap of the same length.
- R9: With `valid_i` at 1 and `stall_i` at 0 continuously, one item is delivered on every cycle once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Producer has an item on `data_i` |
| data_i | input | DATA_W | Producer item |
| stall_o | output | 1 | Pipeline cannot accept an item this cycle |
| valid_o | output | 1 | Last stage holds an item |
| data_o | output | DATA_W | Item in the last stage |
| stall_i | input | 1 | Consumer cannot take the output item |

## Verification
Inputs change at the falling edge, and outputs are read 2 ns later, when the combinational stall chain has settled. At that point `stall_o` already reflects the current `stall_i` in the same cycle, while `valid_o` and `data_o` reflect the last rising edge. An accepted item is therefore due on the output at the read `STAGES` cycles after the one in which it was taken, and a held output is compared one read later against the values seen during the hold. Acceptance and consumption are decided from the same mid-cycle read, so the bench's occupancy count is exact at every read. This count is what the `stall_o` check is based on.

// File: rtl/elastic_pipe_pkg.sv
package elastic_pipe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FULL    = 2'd1,
    ST_HELD    = 2'd2
  } slot_state_e;

  function automatic slot_state_e slot_state(input logic full, input logic held);
    if (!full)     return ST_IDLE;
    else if (held) return ST_HELD;
    else           return ST_FULL;
  endfunction

endpackage

// File: rtl/elastic_clk_gate.sv
module elastic_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  logic en_q;

  // Enable tracks during clock low, frozen while high: no glitch on gclk_o.
  always_latch begin
    if (!clk_i) en_q = en_i;
  end

  assign gclk_o = clk_i & en_q;

endmodule

// File: rtl/elastic_stage.sv
module elastic_stage
  import elastic_pipe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stall_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stall_o
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              load_en, adv_en;
  logic              data_gclk, flag_gclk;
  slot_state_e       state;

  // Only an occupied slot forwards a stall.
  assign stall_o = stall_i & full_q;
  assign adv_en  = ~stall_o;
  assign load_en = valid_i & ~stall_o;
  assign state   = slot_state(full_q, stall_o);

  elastic_clk_gate i_data_gate (
    .clk_i  (clk_i),
    .en_i   (load_en),
    .gclk_o (data_gclk)
  );

  elastic_clk_gate i_flag_gate (
    .clk_i  (clk_i),
    .en_i   (adv_en),
    .gclk_o (flag_gclk)
  );

  always_ff @(posedge flag_gclk or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= valid_i;
  end

  always_ff @(posedge data_gclk) begin
    data_q <= data_i;
  end

  assign valid_o = full_q;
  assign data_o  = data_q;

  a_r2_load_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !stall_o) |=> (valid_o && data_o == $past(data_i)));

  a_r6_held_slot_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HELD) |=> (valid_o && $stable(data_o)));

  a_r8_hole_moves_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !stall_o) |=> !valid_o);

  a_r3_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !stall_o);

endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe #(
  parameter int unsigned STAGES = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stall_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              stall_i
);

  localparam int unsigned LINKS = STAGES + 1;

  logic [LINKS-1:0]  vld_link;
  logic [LINKS-1:0]  stl_link;
  logic [DATA_W-1:0] dat_link [LINKS];
  logic [STAGES-1:0] occupied;

  assign vld_link[0]        = valid_i;
  assign dat_link[0]        = data_i;
  assign stl_link[STAGES]   = stall_i;
  assign stall_o            = stl_link[0];
  assign valid_o            = vld_link[STAGES];
  assign data_o             = dat_link[STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    elastic_stage #(.DATA_W(DATA_W)) i_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (vld_link[k]),
      .data_i  (dat_link[k]),
      .stall_i (stl_link[k+1]),
      .valid_o (vld_link[k+1]),
      .data_o  (dat_link[k+1]),
      .stall_o (stl_link[k])
    );
    assign occupied[k] = vld_link[k+1];
  end

  a_r3_halt_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (&occupied && stall_i));

  a_r3_full_and_stalled_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&occupied && stall_i) |-> stall_o);

  a_r6_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stall_i) |=> (valid_o && $stable(data_o)));

endmodule

// File: tb/test_elastic_pipe.sv
`timescale 1ns/1ps
module test_elastic_pipe;

  localparam int N = 4;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         stall_i = 1'b0;
  logic         stall_o, valid_o;
  logic [W-1:0] data_o;

  always #10 clk_i = ~clk_i;

  elastic_pipe #(.STAGES(N), .DATA_W(W)) i_elastic_pipe (
    .clk_i, .rst_ni, .valid_i, .data_i, .stall_o, .valid_o, .data_o, .stall_i
  );

  int errors = 0;
  int checks = 0;
  logic [W-1:0] ref_q [0:4095];
  int wr = 0, rd = 0, inflight = 0;
  int next_val = 1;
  logic prev_hold = 1'b0;
  logic [W-1:0] prev_data = '0;
  logic seen_valid;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, read mid-low-phase, then cross a rising edge.
  task automatic step(input bit v, input bit s);
    bit acc, pop;
    @(negedge clk_i);
    valid_i = v;
    stall_i = s;
    data_i  = W'(next_val);
    #2;
    check(stall_o == (s && inflight == N), "R3 stall_o", stall_o, int'(s && inflight == N));
    if (prev_hold) begin
      check(valid_o == 1'b1, "R6 valid held", valid_o, 1);
      check(data_o == prev_data, "R6 data held", data_o, prev_data);
    end
    seen_valid = valid_o;
    acc = v && !stall_o;
    pop = valid_o && !s;
    if (pop) begin
      check(rd < wr, "R7 no extra item", rd, wr);
      check(data_o == ref_q[rd % 4096], "R5 order", data_o, ref_q[rd % 4096]);
      rd++;
    end
    if (acc) begin
      ref_q[wr % 4096] = data_i;
      wr++;
      next_val++;
    end
    inflight  = inflight + int'(acc) - int'(pop);
    prev_hold = valid_o && s;
    prev_data = data_o;
    @(posedge clk_i);
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    stall_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid_o in reset", valid_o, 0);
    check(stall_o == 1'b0, "R1 stall_o in reset", stall_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    #2;
    check(valid_o == 1'b0, "R1 valid_o after reset", valid_o, 0);
    check(stall_o == 1'b0, "R1 stall_o after reset", stall_o, 0);

    // R4 latency of a single item through an empty pipeline
    step(1'b1, 1'b0);
    for (int k = 1; k <= N + 1; k++) begin
      step(1'b0, 1'b0);
      check(seen_valid == (k == N), "R4 latency", seen_valid, int'(k == N));
    end

    // R8 gap pattern 1,0,1 arrives as 1,0,1
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
    for (int k = 3; k <= N + 3; k++) begin
      step(1'b0, 1'b0);
      if (k >= N && k <= N + 2)
        check(seen_valid == (k != N + 1), "R8 gap preserved", seen_valid, int'(k != N + 1));
    end

    // R9 full throughput
    for (int k = 0; k < 3 * N; k++) begin
      step(1'b1, 1'b0);
      if (k >= N) check(seen_valid == 1'b1, "R9 one per cycle", seen_valid, 1);
    end
    for (int k = 0; k < N + 1; k++) step(1'b0, 1'b0);
    check(inflight == 0, "R5 drained", inflight, 0);

    // R3 fill against a stalled consumer, then release
    for (int k = 0; k < N + 3; k++) step(1'b1, 1'b1);
    check(inflight == N, "R3 full at halt", inflight, N);
    for (int k = 0; k < N + 2; k++) step(1'b0, 1'b0);

    // R2 R5 R6 R7 random sweeps at several densities
    for (int vq = 0; vq < 4; vq++) begin
      for (int sq = 0; sq < 4; sq++) begin
        for (int c = 0; c < 400; c++) begin
          bit v, s;
          next_rand();
          v = (lfsr[1:0] <= 2'(vq));
          s = (lfsr[5:4] <= 2'(sq)) && (sq != 0 || lfsr[7]);
          step(v, s);
        end
      end
    end
    for (int k = 0; k < N + 2; k++) step(1'b0, 1'b0);
    check(inflight == 0, "R5 none lost", inflight, 0);
    check(rd == wr, "R5 count match", rd, wr);
    check(seen_valid == 1'b0, "R7 empty after drain", seen_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule